// File: doc/BRIEF.md
# 64-bit Compare Timer

A machine timer for a processor subsystem. A 64-bit counter advances by a programmable step each time a programmable prescale period runs out. It is compared against a 64-bit compare value. The block drives two outputs. The first is a raw timer line, which follows the comparison directly. The second is a maskable peripheral interrupt, which comes from a sticky status bit, a per-source enable, and a software test path. Software reaches all of this through 32-bit word registers on a request/response port.

The request channel is valid/ready, and `req_ready` is held high, so a request is accepted in the cycle it is presented and the block never applies back-pressure. Every accepted read returns exactly one response, with `rsp_valid` high one cycle later. Writes return no response. The requester must be able to take a response in every cycle, because the response channel has no ready.

Register byte offsets:

| Offset | Register | Notes |
|---|---|---|
| 0x000 | alert test | write-only |
| 0x004 | run control | bit 0 is the run bit |
| 0x100 | rate | prescale in bits 11:0, step in bits 23:16 |
| 0x104 | counter low | read-only |
| 0x108 | counter high | read-only |
| 0x10C | compare low | |
| 0x110 | compare high | |
| 0x114 | enable | bit 0 |
| 0x118 | status | bit 0 |
| 0x11C | inject | write-only, bit 0 |

Top module: `cmp_timer`

## Requirements
- R1: After reset the registers read as follows, and `mtip` and `irq` are low:
  - run control reads 0.
  - rate reads 0x00010000, which is step 1 and prescale 0.
  - both compare words read 0xFFFFFFFF.
  - enable and status read 0.
  - counter low and counter high read 0.
- R2: While run bit 0 is clear, the counter holds its value and `mtip` is low. A compare match does not set status bit 0, even when the enable bit is set.
- R3: While the run bit is set, the counter adds the step field (bits 23:16 of the rate register) once every prescale+1 cycles, where prescale is bits 11:0. The sum wraps modulo 2^64.
- R4: `mtip` is high in the cycle after a cycle in which the run bit is set and the compare value is less than or equal to the counter. Otherwise it is low. It does not depend on the enable bit.
- R5: A compare match while the run bit and enable bit 0 are both set sets status bit 0 on the next edge. `irq` is high exactly when status bit 0 and enable bit 0 are both set.
- R6: A write to status clears bit 0 when write-data bit 0 is 1. Writing 0 to that bit leaves it unchanged.
- R7: Writing 1 to bit 0 of inject sets status bit 0, but only when enable bit 0 is set. If enable bit 0 is clear, the write has no effect.
- R8: The following accesses have no effect and, for reads, return 0:
  - a write whose `req_be` is not 4'hF has no effect;
  - a read whose `req_be` is not 4'hF returns 0;
  - a read of alert test, inject, or any unmapped offset returns 0;
  - a write to either counter word has no effect.
- R9: A read of counter low captures the counter's upper 32 bits. The next read of counter high returns that captured value.
- R10: Every accepted read produces `rsp_valid` high for exactly one cycle, one cycle after the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is a valid access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| mtip | output | 1 | Raw timer interrupt line |
| irq | output | 1 | Maskable peripheral interrupt |

## Verification
The counter cannot be written, so the hardest case to reach from the ports is a counter whose upper word is nonzero, together with the low/high capture across a carry. Such a value lies beyond millions of cycles even at the largest step. The stimulus therefore reaches comparisons on the upper word in two ways. It sets compare-high words that are never reached, and it places a compare-low just ahead of a counter value that was read back. It also checks the captured high word against a behavioural model on every response. The model also covers two same-edge collisions: a status clear against a still-true match, and the inject path with the enable bit clear.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int PRE_W    = 12;
  localparam int STEP_W   = 8;
  localparam int STEP_LSB = 16;

  localparam logic [9:0] A_ALERT  = 10'h000;
  localparam logic [9:0] A_CTRL   = 10'h004;
  localparam logic [9:0] A_RATE   = 10'h100;
  localparam logic [9:0] A_CNT_LO = 10'h104;
  localparam logic [9:0] A_CNT_HI = 10'h108;
  localparam logic [9:0] A_CMP_LO = 10'h10C;
  localparam logic [9:0] A_CMP_HI = 10'h110;
  localparam logic [9:0] A_IEN    = 10'h114;
  localparam logic [9:0] A_STAT   = 10'h118;
  localparam logic [9:0] A_INJ    = 10'h11C;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick #(
  parameter int CNT_W  = 64,
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cnt
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (!run) begin
      div_q <= '0;
    end else if (div_q >= prescale) begin
      div_q <= '0;
      cnt   <= cnt + CNT_W'(step);
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_cmp.sv
module cmp_timer_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             mtip
);
  assign hit = run && (cmp <= cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mtip <= 1'b0;
    else        mtip <= hit;
  end
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              run,
  output logic [PRE_W-1:0]  prescale,
  output logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cmp,
  output logic              ien,
  output logic              stat
);
  localparam int HI_W = CNT_W - DATA_W;

  logic              full, wr, rd;
  logic [DATA_W-1:0] cmp_lo, rmux;
  logic [HI_W-1:0]   cmp_hi, shadow;
  logic              st_set, st_clr;

  assign full = &req_be;
  assign wr   = req_valid && req_we && full;
  assign rd   = req_valid && !req_we;
  assign cmp  = {cmp_hi, cmp_lo};

  assign st_set = (hit && ien) ||
                  (wr && req_addr == A_INJ && req_wdata[0] && ien);
  assign st_clr = wr && req_addr == A_STAT && req_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      prescale <= '0;
      step     <= STEP_W'(1);
      cmp_lo   <= '1;
      cmp_hi   <= '1;
      ien      <= 1'b0;
      stat     <= 1'b0;
    end else begin
      stat <= (stat && !st_clr) || st_set;
      if (wr) begin
        case (req_addr)
          A_CTRL:   run    <= req_wdata[0];
          A_RATE: begin
            prescale <= req_wdata[PRE_W-1:0];
            step     <= req_wdata[STEP_LSB +: STEP_W];
          end
          A_CMP_LO: cmp_lo <= req_wdata;
          A_CMP_HI: cmp_hi <= req_wdata[HI_W-1:0];
          A_IEN:    ien    <= req_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (req_addr)
      A_CTRL:   rmux[0] = run;
      A_RATE: begin
        rmux[PRE_W-1:0]          = prescale;
        rmux[STEP_LSB +: STEP_W] = step;
      end
      A_CNT_LO: rmux = cnt[DATA_W-1:0];
      A_CNT_HI: rmux[HI_W-1:0] = shadow;
      A_CMP_LO: rmux = cmp_lo;
      A_CMP_HI: rmux[HI_W-1:0] = cmp_hi;
      A_IEN:    rmux[0] = ien;
      A_STAT:   rmux[0] = stat;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      shadow    <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= (rd && full) ? rmux : '0;
      if (rd && full && req_addr == A_CNT_LO) shadow <= cnt[CNT_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                mtip,
  output logic                irq
);
  logic              run, hit, ien, stat;
  logic [PRE_W-1:0]  prescale;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt, cmp;

  assign req_ready = 1'b1;
  assign irq       = stat && ien;

  cmp_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .cnt(cnt), .hit(hit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .run(run), .prescale(prescale), .step(step), .cmp(cmp),
    .ien(ien), .stat(stat)
  );

  cmp_timer_tick #(.CNT_W(CNT_W), .PRE_W(PRE_W), .STEP_W(STEP_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale),
    .step(step), .cnt(cnt)
  );

  cmp_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .cmp(cmp),
    .hit(hit), .mtip(mtip)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_we,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [DATA_W/8-1:0] req_be,
  input logic [DATA_W-1:0]   req_wdata,
  input logic                run,
  input logic [CNT_W-1:0]    cnt,
  input logic [STEP_W-1:0]   step,
  input logic                hit,
  input logic                mtip,
  input logic                ien,
  input logic                stat,
  input logic                rsp_valid,
  input logic [DATA_W-1:0]   rsp_data
);
  logic full_wr;
  assign full_wr = req_valid && req_we && (&req_be);

  p_quiet_mtip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mtip);
  p_hold_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
  p_step_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'($past(step))));
  p_mtip_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> mtip);
  p_stat_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien) |=> stat);
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && req_addr == A_STAT && req_wdata[0] && !(hit && ien)) |=> !stat);
  p_inject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && req_addr == A_INJ && req_wdata[0] && ien) |=> stat);
  p_partial_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !(&req_be)) |=> (rsp_data == '0));
  p_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  p_no_wr_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);
endmodule

bind cmp_timer cmp_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
  .run(run), .cnt(cnt), .step(step), .hit(hit), .mtip(mtip),
  .ien(ien), .stat(stat), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mtip, irq;
  logic [31:0] rsp_data;

  int    n_run = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 0;

  // reference model state
  bit          m_run, m_ien, m_st, m_mtip, m_rv;
  int          m_pre, m_step, m_ph;
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_shadow, m_rd;

  always #2 clk = ~clk;

  cmp_timer u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mtip(mtip), .irq(irq));

  task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_ien = 0; m_st = 0; m_mtip = 0; m_rv = 0; m_rd = 0;
      m_pre = 0; m_step = 1; m_ph = 0; m_cnt = 0; m_cmp = '1; m_shadow = 0;
    end else begin
      bit hit, full, wr, set, clr;
      hit  = m_run && (m_cmp <= m_cnt);
      full = (req_be == 4'hF);
      wr   = req_valid && req_we && full;
      m_rv = req_valid && !req_we;
      m_rd = 0;
      if (m_rv && full) begin
        case (req_addr)
          10'h004: m_rd = {31'b0, m_run};
          10'h100: m_rd = (m_step << 16) | m_pre;
          10'h104: begin m_rd = m_cnt[31:0]; m_shadow = m_cnt[63:32]; end
          10'h108: m_rd = m_shadow;
          10'h10C: m_rd = m_cmp[31:0];
          10'h110: m_rd = m_cmp[63:32];
          10'h114: m_rd = {31'b0, m_ien};
          10'h118: m_rd = {31'b0, m_st};
          default: m_rd = 0;
        endcase
      end
      if (!m_run) m_ph = 0;
      else if (m_ph >= m_pre) begin m_ph = 0; m_cnt = m_cnt + 64'(m_step); end
      else m_ph++;
      set = (hit && m_ien) || (wr && req_addr == 10'h11C && req_wdata[0] && m_ien);
      clr = wr && req_addr == 10'h118 && req_wdata[0];
      m_st = (m_st && !clr) || set;
      if (wr) begin
        case (req_addr)
          10'h004: m_run = req_wdata[0];
          10'h100: begin m_pre = int'(req_wdata[11:0]); m_step = int'(req_wdata[23:16]); end
          10'h10C: m_cmp[31:0]  = req_wdata;
          10'h110: m_cmp[63:32] = req_wdata;
          10'h114: m_ien = req_wdata[0];
          default: ;
        endcase
      end
      m_mtip = hit;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 mtip", 64'(mtip), 64'(m_mtip));
      check("R5 irq", 64'(irq), 64'(m_st && m_ien));
      check("R10 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) check({tag, " rsp_data"}, 64'(rsp_data), 64'(m_rd));
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_be = 4'hF;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0; req_be = 4'hF;
    d = rsp_data;
  endtask

  task automatic rd_exp(input string t, input logic [9:0] a, input logic [31:0] e,
                        input logic [3:0] be = 4'hF);
    logic [31:0] d;
    tag = t;
    rd(a, d, be);
    check(t, 64'(d), 64'(e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] a, b;
    idle(3);
    rst_n = 1;
    check("R1 mtip", 64'(mtip), 0);
    check("R1 irq", 64'(irq), 0);
    rd_exp("R1 ctrl", 10'h004, 0);
    rd_exp("R1 rate", 10'h100, 32'h0001_0000);
    rd_exp("R1 cmp_lo", 10'h10C, 32'hFFFF_FFFF);
    rd_exp("R1 cmp_hi", 10'h110, 32'hFFFF_FFFF);
    rd_exp("R1 ien", 10'h114, 0);
    rd_exp("R1 stat", 10'h118, 0);
    rd_exp("R1 cnt_lo", 10'h104, 0);
    rd_exp("R1 cnt_hi", 10'h108, 0);

    // R2: idle, match would hold but run is clear
    wr(10'h10C, 0); wr(10'h110, 0); wr(10'h114, 1);
    idle(20);
    check("R2 mtip", 64'(mtip), 0);
    rd_exp("R2 cnt_lo", 10'h104, 0);
    rd_exp("R2 stat", 10'h118, 0);
    wr(10'h114, 0); wr(10'h110, 32'h1);

    // R3: step 7 prescale 0 -> two reads two cycles apart differ by 14
    wr(10'h100, 32'h0007_0000); wr(10'h004, 1);
    idle(5);
    tag = "R3"; rd(10'h104, a); rd(10'h104, b);
    check("R3 step7 delta", 64'(b - a), 14);
    wr(10'h100, 32'h0003_0001);
    idle(4);
    tag = "R3"; rd(10'h104, a); rd(10'h104, b);
    check("R3 step3 pre1 delta", 64'(b - a), 3);
    wr(10'h100, 32'h0005_0003);
    idle(40);
    tag = "R3"; rd(10'h104, a); rd(10'h104, b);
    idle(7);
    tag = "R9"; rd(10'h108, b);
    check("R9 hi shadow", 64'(b), 0);

    // R4: match without enable
    wr(10'h100, 32'h0001_0000);
    tag = "R4"; rd(10'h104, a);
    wr(10'h110, 0); wr(10'h10C, a + 30);
    idle(40);
    check("R4 mtip high", 64'(mtip), 1);
    rd_exp("R4 stat untouched", 10'h118, 0);

    // R5: enable -> status sticks, irq high
    wr(10'h114, 1);
    idle(2);
    check("R5 irq", 64'(irq), 1);
    rd_exp("R5 stat", 10'h118, 1);

    // R6: W1C
    wr(10'h110, 32'hFFFF_FFFF);
    wr(10'h118, 0);
    rd_exp("R6 write0 keeps", 10'h118, 1);
    wr(10'h118, 1);
    rd_exp("R6 cleared", 10'h118, 0);
    check("R6 irq low", 64'(irq), 0);
    check("R4 mtip low", 64'(mtip), 0);

    // R7: inject
    wr(10'h114, 0); wr(10'h11C, 1);
    rd_exp("R7 gated inject", 10'h118, 0);
    wr(10'h114, 1); wr(10'h11C, 1);
    rd_exp("R7 inject", 10'h118, 1);
    check("R7 irq", 64'(irq), 1);
    wr(10'h118, 1);

    // R8: partial and unmapped accesses
    wr(10'h004, 0, 4'h1);
    rd_exp("R8 partial write ignored", 10'h004, 1);
    rd_exp("R8 partial read", 10'h100, 0, 4'h3);
    rd_exp("R8 alert read", 10'h000, 0);
    rd_exp("R8 inject read", 10'h11C, 0);
    rd_exp("R8 unmapped", 10'h200, 0);
    wr(10'h104, 0); wr(10'h108, 32'h5);
    tag = "R8"; rd(10'h104, a);
    check("R8 counter write ignored", 64'(a != 0), 1);
    rd_exp("R9 hi after lo", 10'h108, 0);

    // R2: stop with a match present
    wr(10'h110, 0); wr(10'h10C, 0);
    idle(3);
    wr(10'h004, 0);
    wr(10'h118, 1);
    idle(10);
    check("R2 mtip stopped", 64'(mtip), 0);
    rd_exp("R2 stat stays clear", 10'h118, 0);
    tag = "R2"; rd(10'h104, a); idle(10); rd(10'h104, b);
    check("R2 counter held", 64'(b), 64'(a));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule